// File: doc/BRIEF.md
# Reference-Table Fault Outcome Checker

This block judges the effect of a single injected bit-flip on one faulty instance of a design. No golden twin runs beside it. The bench or a host preloads two small memories. One holds the stimulus words that are replayed into the instance, one word per cycle. The other holds the output word the instance is expected to show in each cycle of a fault-free run.

The block starts a replay on a start pulse. It flips exactly one state bit of the instance on a programmed cycle. It then compares the instance output against the expected table on every cycle. The comparison is relaxed: after the first disagreement, the output may differ from the table for a programmable number of cycles. This window lets the workload's own redundancy repair the damage. At the end of the replay the block latches one of three verdicts and raises a done flag.

The instance here is a small stand-in core. It has a one-word input stage and an accumulator. The accumulator is cleared whenever a zero word passes through the stage, so a zero word in the stimulus acts as the workload's recovery point.

Top module: `ftc_ref_checker`

## Requirements
- R1: While reset is asserted and after it is released, busy_o, done_o and status_o are all 0.
- R2: A write with tbl_we_i high stores tbl_wdata_i at tbl_addr_i. The target table is chosen by tbl_sel_i: 0 selects the stimulus table and 1 selects the expected-output table.
- R3: A start_i pulse while idle samples run_len_i, window_i, inj_cycle_i and inj_index_i, then replays cycles 0 to L-1. L is run_len_i, clamped so that 0 becomes 1 and values above DEPTH become DEPTH. busy_o is high in the first replay cycle. done_o rises in the cycle after the last replay cycle. start_i during a replay, and changes to the configuration inputs during a replay, have no effect.
- R4: In replay cycle t, the stand-in core receives stimulus word t and its output is compared with expected word t. The core has a stage register and an accumulator. The stage loads the input. The accumulator becomes 0 if the stage is zero, and otherwise becomes the accumulator plus the stage, modulo 2^DATA_W. The output is the accumulator. Both registers are 0 in replay cycle 0.
- R5: At the end of replay cycle inj_cycle_i, state bit inj_index_i is inverted once. Indices 0 to DATA_W-1 address stage bits and indices DATA_W to 2*DATA_W-1 address accumulator bits. A larger index flips nothing. An inj_cycle_i of L or more flips nothing. A flip made at the end of the last cycle is never compared.
- R6: If no replay cycle mismatches, status_o is 2'b00 (no effect). The code 2'b11 never appears.
- R7: Let f be the first mismatching cycle and W the sampled window. If every mismatch lies before cycle f+W and the last replay cycle matches, status_o is 2'b01 (recovered).
- R8: If any mismatch falls at a cycle f+W or later, or the last replay cycle mismatches, status_o is 2'b10 (failed). With W = 0, any mismatch fails.
- R9: done_o and status_o hold until the next accepted start, which clears done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_sel_i | input | 1 | Table select: 0 stimulus, 1 expected output |
| tbl_addr_i | input | $clog2(DEPTH) | Table write address |
| tbl_wdata_i | input | DATA_W | Table write data |
| start_i | input | 1 | Begin a replay (accepted only when idle) |
| run_len_i | input | $clog2(DEPTH)+1 | Replay length in cycles |
| window_i | input | WIN_W | Recovery window in cycles |
| inj_cycle_i | input | $clog2(DEPTH)+1 | Replay cycle at whose end the flip is made |
| inj_index_i | input | $clog2(2*DATA_W)+1 | Index of the state bit to flip |
| busy_o | output | 1 | Replay in progress |
| done_o | output | 1 | Verdict valid |
| status_o | output | 2 | Verdict: 00 no effect, 01 recovered, 10 failed |

## Verification
Two pairs of functions can land on the same cycle. The first pair is the flip and the verdict latch: when the flip is programmed at the end of the last replay cycle, it happens on the very edge that latches the verdict. The bench requires "no effect" here, because the corrupted state is never compared. The second pair is the first mismatch and the window expiry: with a window of zero, the cycle that opens the window also closes it. The bench requires "failed" for that case. It then sweeps the window to exactly the measured mismatch span and to one cycle less, which must give recovered and failed respectively.

// File: rtl/ftc_pkg.sv
`timescale 1ns/1ps
package ftc_pkg;

  typedef enum logic [1:0] {
    FTC_NO_EFFECT = 2'b00,
    FTC_RECOVERED = 2'b01,
    FTC_FAILED    = 2'b10
  } ftc_status_e;

  // Verdict from "a mismatch was seen" and "the window rule was broken".
  function automatic ftc_status_e ftc_classify(input logic seen, input logic broken);
    if (!seen)  return FTC_NO_EFFECT;
    if (broken) return FTC_FAILED;
    return FTC_RECOVERED;
  endfunction

endpackage

// File: rtl/ftc_word_ram.sv
`timescale 1ns/1ps
module ftc_word_ram #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8
) (
  input  logic                     clk_i,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] waddr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [$clog2(DEPTH)-1:0] raddr_i,
  output logic [DATA_W-1:0]        rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // Asynchronous read: the word for replay cycle t is ready in cycle t.
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ftc_standin_core.sv
`timescale 1ns/1ps
module ftc_standin_core #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              flip_i,
  input  logic [IDX_W-1:0]  flip_idx_i,
  output logic [DATA_W-1:0] dout_o
);
  localparam int ST_W = 2 * DATA_W;

  // Accumulator update: a zero word in the stage resynchronises the state.
  function automatic logic [DATA_W-1:0] acc_step(input logic [DATA_W-1:0] stage,
                                                 input logic [DATA_W-1:0] acc);
    if (stage == '0) return '0;
    return acc + stage;
  endfunction

  logic [ST_W-1:0] state_q, state_d, flip_mask;

  // One-hot mask; an index beyond the state leaves it all zero.
  for (genvar b = 0; b < ST_W; b++) begin : g_mask
    assign flip_mask[b] = flip_i && (flip_idx_i == IDX_W'(b));
  end

  // Layout: {accumulator, stage}.
  assign state_d = {acc_step(state_q[DATA_W-1:0], state_q[ST_W-1:DATA_W]), din_i} ^ flip_mask;

  always_ff @(posedge clk_i) begin
    if (!rst_ni || clear_i) state_q <= '0;
    else if (step_i)        state_q <= state_d;
  end

  assign dout_o = state_q[ST_W-1:DATA_W];
endmodule

// File: rtl/ftc_verdict.sv
`timescale 1ns/1ps
module ftc_verdict
  import ftc_pkg::*;
#(
  parameter int WIN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             active_i,
  input  logic             mism_i,
  input  logic [WIN_W-1:0] window_i,
  output logic             first_o,
  output logic             late_o,
  output logic             seen_o,
  output logic             fail_o,
  output logic [1:0]       final_o
);
  localparam int AGE_W = WIN_W + 1;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic             seen_q, fail_q;
  logic [AGE_W-1:0] age_q, age_now;
  logic             hit;

  // age_now is the distance in cycles from the first mismatch (0 on that cycle).
  assign hit     = active_i && mism_i;
  assign age_now = seen_q ? age_q : '0;
  assign first_o = hit && !seen_q;
  assign late_o  = hit && (age_now >= {1'b0, window_i});
  assign seen_o  = seen_q;
  assign fail_o  = fail_q;

  // Verdict valid on the last replay cycle; a mismatch there also fails.
  assign final_o = ftc_classify(seen_q || first_o, fail_q || late_o || hit);

  always_ff @(posedge clk_i) begin
    if (!rst_ni || clear_i) begin
      seen_q <= 1'b0;
      fail_q <= 1'b0;
      age_q  <= '0;
    end else if (active_i) begin
      if (first_o) begin
        seen_q <= 1'b1;
        age_q  <= AGE_W'(1);
      end else if (seen_q && age_q != AGE_MAX) begin
        age_q  <= age_q + AGE_W'(1);
      end
      if (late_o) fail_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ftc_ref_checker.sv
`timescale 1ns/1ps
module ftc_ref_checker #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  parameter int WIN_W  = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          tbl_we_i,
  input  logic                          tbl_sel_i,
  input  logic [$clog2(DEPTH)-1:0]      tbl_addr_i,
  input  logic [DATA_W-1:0]             tbl_wdata_i,
  input  logic                          start_i,
  input  logic [$clog2(DEPTH):0]        run_len_i,
  input  logic [WIN_W-1:0]              window_i,
  input  logic [$clog2(DEPTH):0]        inj_cycle_i,
  input  logic [$clog2(2*DATA_W):0]     inj_index_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic [1:0]                    status_o
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int CNT_W  = ADDR_W + 1;
  localparam int IDX_W  = $clog2(2 * DATA_W) + 1;

  function automatic logic [CNT_W-1:0] clamp_len(input logic [CNT_W-1:0] n);
    if (n == '0)              return CNT_W'(1);
    if (n > CNT_W'(DEPTH))    return CNT_W'(DEPTH);
    return n;
  endfunction

  logic             busy_q, done_q;
  logic [1:0]       status_q;
  logic [CNT_W-1:0] cyc_q, len_q, icyc_q;
  logic [WIN_W-1:0] win_q;
  logic [IDX_W-1:0] iidx_q;

  // Named internal events
  logic start_ok, run_last, inject_pulse, mismatch;
  logic first_err, late_err, seen_flag, fail_flag;
  logic [1:0] final_status;

  logic [DATA_W-1:0] tbl_rd [2];
  logic [DATA_W-1:0] stim_word, exp_word, dut_out;

  assign start_ok     = start_i && !busy_q;
  assign run_last     = busy_q && (cyc_q == len_q - CNT_W'(1));
  assign inject_pulse = busy_q && (cyc_q == icyc_q);

  // Table 0 holds stimulus words, table 1 holds expected output words.
  for (genvar g = 0; g < 2; g++) begin : g_tbl
    ftc_word_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ram (
      .clk_i   (clk_i),
      .we_i    (tbl_we_i && (tbl_sel_i == 1'(g))),
      .waddr_i (tbl_addr_i),
      .wdata_i (tbl_wdata_i),
      .raddr_i (cyc_q[ADDR_W-1:0]),
      .rdata_o (tbl_rd[g])
    );
  end

  assign stim_word = tbl_rd[0];
  assign exp_word  = tbl_rd[1];

  ftc_standin_core #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (start_ok),
    .step_i     (busy_q),
    .din_i      (stim_word),
    .flip_i     (inject_pulse),
    .flip_idx_i (iidx_q),
    .dout_o     (dut_out)
  );

  assign mismatch = busy_q && (dut_out != exp_word);

  ftc_verdict #(.WIN_W(WIN_W)) u_verdict (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (start_ok),
    .active_i (busy_q),
    .mism_i   (mismatch),
    .window_i (win_q),
    .first_o  (first_err),
    .late_o   (late_err),
    .seen_o   (seen_flag),
    .fail_o   (fail_flag),
    .final_o  (final_status)
  );

  // Replay sequencer
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      status_q <= 2'b00;
      cyc_q    <= '0;
      len_q    <= CNT_W'(1);
      icyc_q   <= '0;
      win_q    <= '0;
      iidx_q   <= '0;
    end else if (start_ok) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      cyc_q  <= '0;
      len_q  <= clamp_len(run_len_i);
      icyc_q <= inj_cycle_i;
      win_q  <= window_i;
      iidx_q <= inj_index_i;
    end else if (busy_q) begin
      if (run_last) begin
        busy_q   <= 1'b0;
        done_q   <= 1'b1;
        status_q <= final_status;
      end else begin
        cyc_q <= cyc_q + CNT_W'(1);
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign status_o = status_q;
endmodule

// File: rtl/ftc_ref_checker_sva.sv
`timescale 1ns/1ps
module ftc_ref_checker_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic [1:0] status_o,
  input logic       run_last,
  input logic       first_err,
  input logic       late_err,
  input logic       seen_flag,
  input logic       fail_flag
);
  assert_done_after_last_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_last |=> done_o && !busy_o);

  assert_busy_done_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  assert_code_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o != 2'b11);

  assert_none_verdict_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_last && !seen_flag && !first_err |=> status_o == 2'b00);

  assert_first_marks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_err |=> seen_flag);

  assert_late_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_err && !run_last |=> fail_flag);

  assert_fail_verdict_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_last && (late_err || fail_flag) |=> status_o == 2'b10);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && $stable(status_o));
endmodule

bind ftc_ref_checker ftc_ref_checker_sva u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .status_o  (status_o),
  .run_last  (run_last),
  .first_err (first_err),
  .late_err  (late_err),
  .seen_flag (seen_flag),
  .fail_flag (fail_flag)
);

// File: tb/ftc_ref_checker_test.sv
`timescale 1ns/1ps
module ftc_ref_checker_test;
  localparam int DW = 8;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, tbl_we, tbl_sel, start;
  logic [4:0] tbl_addr;
  logic [7:0] tbl_wdata, window;
  logic [5:0] run_len, inj_cycle;
  logic [4:0] inj_index;
  logic       busy_o, done_o;
  logic [1:0] status_o;

  ftc_ref_checker uut (
    .clk_i(clk), .rst_ni(rst_n), .tbl_we_i(tbl_we), .tbl_sel_i(tbl_sel),
    .tbl_addr_i(tbl_addr), .tbl_wdata_i(tbl_wdata), .start_i(start),
    .run_len_i(run_len), .window_i(window), .inj_cycle_i(inj_cycle),
    .inj_index_i(inj_index), .busy_o(busy_o), .done_o(done_o), .status_o(status_o)
  );

  int total = 0, bad = 0;
  logic [1:0] exp_q[$];
  string      req_q[$];
  logic [7:0] stim_m[DEPTH], gold[DEPTH], fault[DEPTH];
  int         f_cyc, l_cyc;
  logic [1:0] last_verdict;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Reference model of the stand-in core (R4) with an optional flip (R5).
  function automatic void run_model(input int len, input int ic, input int idx, input bit golden);
    logic [7:0] st = 8'd0, ac = 8'd0, nst, nac;
    for (int t = 0; t < len; t++) begin
      if (golden) gold[t] = ac; else fault[t] = ac;
      nst = stim_m[t];
      nac = (st == 8'd0) ? 8'd0 : ac + st;
      if (!golden && t == ic && idx < 2*DW) begin
        if (idx < DW) nst[idx] = ~nst[idx];
        else          nac[idx-DW] = ~nac[idx-DW];
      end
      st = nst;
      ac = nac;
    end
  endfunction

  // Verdict rule from R6, R7, R8.
  function automatic logic [1:0] expect_status(input int len, input int win);
    f_cyc = -1;
    l_cyc = -1;
    for (int t = 0; t < len; t++)
      if (fault[t] != gold[t]) begin
        if (f_cyc < 0) f_cyc = t;
        l_cyc = t;
      end
    if (f_cyc < 0) return 2'b00;
    if (l_cyc >= f_cyc + win || fault[len-1] != gold[len-1]) return 2'b10;
    return 2'b01;
  endfunction

  // R2: preload both tables through the write port.
  task automatic load_tables(input int pat);
    for (int t = 0; t < DEPTH; t++)
      stim_m[t] = (pat == 0) ? ((t % 6 == 5) ? 8'd0 : 8'(t*7 + 3)) : 8'(t*5 + 1);
    run_model(DEPTH, 0, 99, 1'b1);
    for (int s = 0; s < 2; s++)
      for (int t = 0; t < DEPTH; t++) begin
        @(negedge clk);
        tbl_we = 1'b1; tbl_sel = 1'(s); tbl_addr = 5'(t);
        tbl_wdata = (s == 0) ? stim_m[t] : gold[t];
      end
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // Driver: push expected verdict, launch a replay, check its timing.
  task automatic run_case(input string req, input int len, input int eff, input int win,
                          input int ic, input int idx, input bit poke);
    int n;
    run_model(eff, ic, idx, 1'b0);
    exp_q.push_back(expect_status(eff, win));
    req_q.push_back(req);
    @(negedge clk);
    start = 1'b1; run_len = 6'(len); window = 8'(win);
    inj_cycle = 6'(ic); inj_index = 5'(idx);
    @(negedge clk);
    start = 1'b0;
    check(busy_o == 1'b1, "R3", "busy in first replay cycle", busy_o, 1);
    if (poke) begin
      window = 8'd0; inj_index = 5'd0; inj_cycle = 6'd1; // must not take effect (R3)
    end
    n = 0;
    while (!done_o && n < 100) begin
      @(negedge clk);
      n++;
      start = poke && (n == 2);
    end
    start = 1'b0;
    check(n == eff, "R3", "cycles from start to done", n, eff);
  endtask

  // Monitor: pop and compare on every new verdict.
  logic done_prev = 1'b0;
  logic [1:0] e_st;
  string e_req;
  always @(negedge clk) begin
    if (rst_n && done_o && !done_prev) begin
      if (exp_q.size() == 0) check(1'b0, "R3", "unexpected verdict", status_o, 0);
      else begin
        e_st  = exp_q.pop_front();
        e_req = req_q.pop_front();
        last_verdict = e_st;
        check(status_o == e_st, e_req, "verdict", status_o, e_st);
      end
    end
    done_prev = done_o;
  end

  initial begin
    #(5ns * 100000);
    check(1'b0, "watchdog", "run did not finish", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w;
    rst_n = 1'b0; tbl_we = 1'b0; tbl_sel = 1'b0; tbl_addr = '0; tbl_wdata = '0;
    start = 1'b0; run_len = '0; window = '0; inj_cycle = '0; inj_index = '0;
    repeat (3) @(negedge clk);
    check({busy_o, done_o, status_o} == 4'b0, "R1", "state in reset", {busy_o, done_o, status_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy_o, done_o, status_o} == 4'b0, "R1", "state after reset", {busy_o, done_o, status_o}, 0);

    load_tables(0);
    run_case("R2", 24, 24, 5, 5, 20, 1'b0);    // index out of range: no flip
    run_case("R5", 24, 24, 5, 30, 3, 1'b0);    // cycle beyond run
    run_case("R5", 24, 24, 5, 23, 10, 1'b0);   // flip on the final cycle: unseen
    run_case("R7", 24, 24, 10, 6, 9, 1'b0);    // accumulator flip, repaired by zero word
    run_case("R8", 24, 24, 0, 6, 9, 1'b0);     // zero window
    run_model(24, 6, 9, 1'b0);
    void'(expect_status(24, 0));
    w = l_cyc - f_cyc + 1;
    run_case("R7", 24, 24, w, 6, 9, 1'b0);     // window just wide enough
    run_case("R8", 24, 24, w - 1, 6, 9, 1'b0); // one cycle short
    run_case("R4", 24, 24, 12, 8, 3, 1'b0);    // stage flip
    run_case("R3", 24, 24, 10, 6, 9, 1'b1);    // restart and config changes ignored
    repeat (4) @(negedge clk);
    check(done_o == 1'b1, "R9", "done held", done_o, 1);
    check(status_o == last_verdict, "R9", "verdict held", status_o, last_verdict);
    run_case("R3", 0, 1, 5, 30, 20, 1'b0);     // length 0 clamps to 1
    run_case("R3", 40, 32, 5, 40, 20, 1'b0);   // length clamps to DEPTH

    load_tables(1);
    run_case("R8", 20, 20, 15, 4, 8, 1'b0);    // no zero word: fault persists

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R3", "verdicts outstanding", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule